// File: doc/BRIEF.md
# Set/Clear Controlled Status Register

This block holds the status and mode word of a synchronous serial controller. Software never writes the status bits directly. Instead it writes a command word in which each bit either sets or clears one status bit. That lets one write change a single bit without disturbing its neighbours, and it leaves no read-modify-write race with hardware updates.

The word carries four groups of state:
- the enable bit, which selects configuration mode (0) or active mode (1);
- the master-select bit;
- six sticky error flags, raised by hardware error events;
- a 3-bit count of valid bytes in the last received word.

A live busy indication from the shifter is also mirrored into the word. Five of the error sources are gated by per-source enable inputs. The mode error is always recorded. A combined error interrupt stays high while any error flag is set.

Top module: `ssc_stat_ctrl`

## Requirements
- R1: While `rst_n` is low, `status` is all zeros and `err_irq` is low. This is configuration mode with master select cleared.
- R2: A command write (`cmd_we` high) with `cmd[0]` set clears status bit 0 (enable). With `cmd[1]` set it sets status bit 0. The new value is visible in the cycle after the write.
- R3: A command write with `cmd[2]` set clears status bit 1 (master select). With `cmd[3]` set it sets status bit 1. The new value is visible in the cycle after the write.
- R4: The error flags sit at these status bits, each with its own clear and set command bits:

  | Flag | Status bit | Clear bit | Set bit |
  |---|---|---|---|
  | mode | 7 | 6 | 7 |
  | transmit overflow | 8 | 8 | 12 |
  | receive overflow | 9 | 9 | 13 |
  | abort | 10 | 10 | 14 |
  | transmit underflow | 11 | 11 | 15 |
  | receive underflow | 12 | 4 | 5 |

  The flag takes its new value in the cycle after the write.
- R5: When a single command sets both the clear and the set bit of the same status bit, the clear takes effect.
- R6: Error flags are sticky. A flag, once set, stays set until it is cleared by command. A hardware event (`err_evt[i]`) arriving in the same cycle as a clear command for that flag leaves the flag set.
- R7: `err_evt[i]` maps to flag i in R4 order: 0 mode, 1 transmit overflow, 2 receive overflow, 3 abort, 4 transmit underflow, 5 receive underflow.
  - The mode error event (i = 0) always sets its flag.
  - Event i for i ≥ 1 sets its flag only when `err_en[i-1]` is high.
  - A gated-off event leaves the flag unchanged.
- R8: `err_irq` is high exactly while at least one of status bits 12:7 is set.
- R9: The status word has these further fields:
  - Bit 13 follows `busy_i` combinationally.
  - Bits 30:28 hold the received-byte-valid count. It is loaded from `rxbv_val` in the cycle after `rxbv_we` is high, and is otherwise held.
  - Every other bit reads zero.
- R10: A command write with no bits set changes nothing. Command bits presented while `cmd_we` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd | input | 16 | Set/clear command word |
| err_evt | input | 6 | Hardware error event pulses, one per flag |
| err_en | input | 5 | Detection enables for error events 1 to 5 |
| busy_i | input | 1 | Shifter busy indication |
| rxbv_we | input | 1 | Load strobe for the received-byte-valid count |
| rxbv_val | input | 3 | Received-byte-valid count to load |
| status | output | 32 | Status and mode word |
| err_irq | output | 1 | Combined error interrupt request |

## Verification
Every state bit of this block is visible on `status` at all times. A wrong set, clear or priority decision therefore shows up as a wrong bit exactly one cycle after the command or event that caused it. A wrong flag also shows on `err_irq` in that same cycle.

The bench compares the whole word and the interrupt against a behavioural model after every clock. Directed phases cover four cases that a random stream reaches only rarely:
- set and clear written together in one command;
- a hardware event coinciding with a clear;
- events arriving with their enable off;
- empty commands.

// File: rtl/ssc_stat_ctrl.sv
module ssc_stat_ctrl #(
  parameter int NERR   = 6,
  parameter int RXBV_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [15:0]       cmd,
  input  logic [NERR-1:0]   err_evt,
  input  logic [NERR-2:0]   err_en,
  input  logic              busy_i,
  input  logic              rxbv_we,
  input  logic [RXBV_W-1:0] rxbv_val,
  output logic [31:0]       status,
  output logic              err_irq
);
  localparam int ERR_LSB  = 7;
  localparam int BUSY_BIT = ERR_LSB + NERR;
  localparam int RXBV_LSB = 28;

  function automatic int clr_pos(int i);
    return (i == 0) ? 6 : (i == 5) ? 4 : 7 + i;
  endfunction

  function automatic int set_pos(int i);
    return (i == 0) ? 7 : (i == 5) ? 5 : 11 + i;
  endfunction

  logic              en_q, ms_q;
  logic [NERR-1:0]   err_q;
  logic [RXBV_W-1:0] rxbv_q;

  wire [15:0] c = cmd_we ? cmd : 16'h0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0;
      ms_q <= 1'b0;
    end else begin
      if (c[0])      en_q <= 1'b0;
      else if (c[1]) en_q <= 1'b1;
      if (c[2])      ms_q <= 1'b0;
      else if (c[3]) ms_q <= 1'b1;
    end

  for (genvar i = 0; i < NERR; i++) begin : g_err
    logic hw;
    if (i == 0) begin : g_ungated
      assign hw = err_evt[i];
    end else begin : g_gated
      assign hw = err_evt[i] & err_en[i-1];
    end
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                err_q[i] <= 1'b0;
      else if (hw)               err_q[i] <= 1'b1;
      else if (c[clr_pos(i)])    err_q[i] <= 1'b0;
      else if (c[set_pos(i)])    err_q[i] <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       rxbv_q <= '0;
    else if (rxbv_we) rxbv_q <= rxbv_val;

  always_comb begin
    status = '0;
    status[0] = en_q;
    status[1] = ms_q;
    status[ERR_LSB +: NERR] = err_q;
    status[BUSY_BIT] = busy_i & rst_n;
    status[RXBV_LSB +: RXBV_W] = rxbv_q;
  end

  assign err_irq = |err_q;
endmodule

module ssc_stat_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_we,
  input logic [15:0] cmd,
  input logic [5:0]  err_evt,
  input logic [4:0]  err_en,
  input logic [31:0] status,
  input logic        err_irq
);
  always @(negedge clk)
    if (!rst_n)
      // R1
      reset_state_chk: assert (status == 32'h0 && !err_irq);

  // R2
  enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd[0] |=> !status[0]);

  // R2
  enable_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd[1] && !cmd[0] |=> status[0]);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(status[1:0]));

  // R5
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd[6] && cmd[7] && !err_evt[0] |=> !status[7]);

  // R6
  evt_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt[0] |=> status[7] && err_irq);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] && !(cmd_we && cmd[6]) |=> status[7]);

  // R7
  gated_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_en[0] && !status[8] && !(cmd_we && cmd[12]) |=> !status[8]);

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq == (status[12:7] != 6'h0));
endmodule

bind ssc_stat_ctrl ssc_stat_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd),
  .err_evt(err_evt), .err_en(err_en), .status(status), .err_irq(err_irq)
);

// File: tb/test_ssc_stat_ctrl.sv
module test_ssc_stat_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd = '0;
  logic [5:0]  err_evt = '0;
  logic [4:0]  err_en = '0;
  logic        busy_i = 1'b0;
  logic        rxbv_we = 1'b0;
  logic [2:0]  rxbv_val = '0;
  logic [31:0] status;
  logic        err_irq;

  ssc_stat_ctrl i_ssc_stat_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cmd),
    .err_evt(err_evt), .err_en(err_en), .busy_i(busy_i),
    .rxbv_we(rxbv_we), .rxbv_val(rxbv_val),
    .status(status), .err_irq(err_irq)
  );

  always #5 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string phase = "R1";
  bit done = 0;

  int clr_b [6] = '{6, 8, 9, 10, 11, 4};
  int set_b [6] = '{7, 12, 13, 14, 15, 5};

  bit       m_en, m_ms;
  bit [5:0] m_err;
  bit [2:0] m_rxbv;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ms = 0; m_err = 0; m_rxbv = 0;
    end else begin
      for (int i = 0; i < 6; i++) begin
        bit hw, c, s;
        hw = err_evt[i] && (i == 0 || err_en[i-1]);
        c  = cmd_we && cmd[clr_b[i]];
        s  = cmd_we && cmd[set_b[i]];
        if (hw)     m_err[i] = 1;
        else if (c) m_err[i] = 0;
        else if (s) m_err[i] = 1;
      end
      if (cmd_we && cmd[0])      m_en = 0;
      else if (cmd_we && cmd[1]) m_en = 1;
      if (cmd_we && cmd[2])      m_ms = 0;
      else if (cmd_we && cmd[3]) m_ms = 1;
      if (rxbv_we) m_rxbv = rxbv_val;
    end
  end

  task automatic compare();
    logic [31:0] exp_s;
    logic exp_i;
    exp_s = '0;
    exp_s[0] = m_en;
    exp_s[1] = m_ms;
    exp_s[12:7] = m_err;
    exp_s[13] = busy_i && rst_n;
    exp_s[30:28] = m_rxbv;
    exp_i = |m_err;
    compared++;
    if (status !== exp_s || err_irq !== exp_i) begin
      mismatched++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               phase, status, err_irq, exp_s, exp_i);
    end
  endtask

  task automatic step(input bit we, input logic [15:0] cw,
                      input logic [5:0] ev = 6'h0, input logic [4:0] en = 5'h1f,
                      input bit bz = 0, input bit rw = 0, input logic [2:0] rv = 0);
    @(negedge clk);
    compare();
    cmd_we = we; cmd = cw; err_evt = ev; err_en = en;
    busy_i = bz; rxbv_we = rw; rxbv_val = rv;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 16'h0);
  endtask

  initial begin
    phase = "R1";
    step(0, 16'hffff, 6'h3f, 5'h1f, 1, 1, 3'd5);
    step(0, 16'hffff, 6'h3f, 5'h1f, 1, 1, 3'd5);
    step(0, 16'h0);
    rst_n = 1'b1;
    idle(2);
    phase = "R2";
    step(1, 16'h0002); step(0, 16'h0);
    step(1, 16'h0001); step(0, 16'h0);
    step(1, 16'h0002); step(1, 16'h0003); step(0, 16'h0);
    phase = "R3";
    step(1, 16'h0008); step(0, 16'h0);
    step(1, 16'h0004); step(1, 16'h0008); step(1, 16'h000c); step(0, 16'h0);
    phase = "R4";
    for (int i = 0; i < 6; i++) begin
      step(1, 16'h1 << set_b[i]); step(0, 16'h0);
      step(1, 16'h1 << clr_b[i]); step(0, 16'h0);
    end
    step(1, 16'hf0a0); step(0, 16'h0); step(1, 16'h0f50); step(0, 16'h0);
    phase = "R5";
    for (int i = 0; i < 6; i++) begin
      step(1, (16'h1 << set_b[i]) | (16'h1 << clr_b[i])); step(0, 16'h0);
    end
    phase = "R6";
    for (int i = 0; i < 6; i++) begin
      step(1, 16'h1 << clr_b[i], 6'h1 << i); idle(3);
      step(1, 16'h1 << clr_b[i]); step(0, 16'h0);
    end
    phase = "R7";
    step(0, 16'h0, 6'h3f, 5'h00); idle(2);
    for (int i = 0; i < 5; i++) begin
      step(0, 16'h0, 6'h3e, 5'h1 << i); step(0, 16'h0);
    end
    phase = "R8";
    step(1, 16'h0f50); step(0, 16'h0);
    step(0, 16'h0, 6'h20, 5'h10); step(1, 16'h0010); step(0, 16'h0);
    phase = "R9";
    step(0, 16'h0, 6'h0, 5'h1f, 1); step(0, 16'h0);
    step(0, 16'h0, 6'h0, 5'h1f, 0, 1, 3'd7); step(0, 16'h0);
    step(0, 16'h0, 6'h0, 5'h1f, 1, 1, 3'd2); idle(2);
    phase = "R10";
    step(1, 16'h00aa); step(1, 16'h0000); idle(1);
    step(0, 16'hffff); step(0, 16'h5555); idle(1);
    phase = "R4";
    begin
      logic [31:0] lf = 32'h1badf00d;
      for (int k = 0; k < 400; k++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        step(lf[0], lf[23:8], (lf[29:24] & {6{lf[3]}}), lf[7:3], lf[2], lf[30], lf[31:29]);
      end
    end
    idle(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule